// File: doc/BRIEF.md
# Tag Store and Capability Tag Guard

This block carries out the tag side of memory operations on a machine whose 64-bit doublewords each hold an 8-bit tag. It covers five operations:

- loading one tag;
- storing one tag;
- storing the eight tags of a 64-byte line at once;
- the tag check of a 128-bit capability load;
- the tag stamping of a 128-bit capability store.

It takes one request per cycle: an opcode, a byte address, the tag operands and a flag saying whether the hart runs in machine mode. It drives the write and read ports of a tag memory that holds eight tags per 64-byte line. It returns one response per request: a 64-bit result and an exception cause.

Tag values 0 to 251 are ordinary clique identifiers. Tag 252 stands for untagged memory, and 253 is reserved. Tags 254 and 255 mark the low and high doublewords of a capability. Only machine mode may write any of the four top values with an explicit tag store, so capability tags cannot be forged from lower privilege. A capability store stamps the 254/255 pair by itself, in any mode. A capability load fails unless it finds exactly that pair.

Tag writes leave the block in the same cycle as the request. Every response appears one cycle after its request.

Top module: `tag_guard_unit`

## Requirements
- R1: A tag load (opcode 0) returns, one cycle after the request, the tag of the addressed doubleword zero-extended to 64 bits. Address bits 2:0 are ignored. The tag of doubleword `addr[5:3]` of line `addr>>6` sits at bits `8*addr[5:3]+7 : 8*addr[5:3]` of the tag memory word.
- R2: A single-tag store (opcode 1) raises exactly the one write enable for lane `addr[5:3]` of line `addr>>6`, with the operand tag on that lane, and reports no exception.
- R3: A single-tag store of a value of 252 or above outside machine mode writes nothing and reports cause 2. The same store in machine mode is performed.
- R4: An eight-tag store (opcode 2) to a 64-byte-aligned address writes all eight lanes of the line. Lane i takes operand bits 8i+7:8i.
- R5: An eight-tag store whose address has any of bits 5:0 set writes nothing and reports cause 1. Outside machine mode, if any of its eight tags is 252 or above, it writes nothing at all and reports cause 2.
- R6: A 16-byte-aligned capability load (opcode 3) reads the line and reports cause 3 unless the even lane `{addr[5:4],0}` holds 254 and the next lane holds 255. Otherwise it reports no exception.
- R7: A capability load or store whose address has any of bits 3:0 set reports cause 1 and neither reads nor writes the tag memory.
- R8: A 16-byte-aligned capability store (opcode 4) writes 254 to the even lane of the pair and 255 to the odd lane, in any privilege mode, and reports no exception.
- R9: Opcodes 5 to 7 report cause 4 and neither read nor write the tag memory.
- R10: Every request yields exactly one response, one cycle later. No response, read or write appears without a request or during reset. The response data is zero for every operation other than a successful tag load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation: 0 tag load, 1 tag store, 2 eight-tag store, 3 capability load, 4 capability store |
| req_addr | input | ADDR_W | Byte address |
| req_tag | input | 8 | Tag operand of the single-tag store |
| req_tags | input | 64 | Eight tag operands of the eight-tag store, lane i at bits 8i+7:8i |
| req_mmode | input | 1 | Hart is in machine mode |
| tm_re | output | 1 | Tag memory read enable |
| tm_ridx | output | ADDR_W-6 | Tag memory read line index |
| tm_rdata | input | 64 | Tag memory read data, valid the cycle after tm_re |
| tm_we | output | 8 | Tag memory per-lane write enables |
| tm_widx | output | ADDR_W-6 | Tag memory write line index |
| tm_wdata | output | 64 | Tag memory write data, lane i at bits 8i+7:8i |
| rsp_valid | output | 1 | A response is present |
| rsp_exc | output | 1 | The response is an exception |
| rsp_cause | output | 3 | 0 none, 1 alignment, 2 privilege, 3 capability tag, 4 unknown opcode |
| rsp_data | output | 64 | Loaded tag, zero-extended |

## Verification
Write enables, write data, read enable and line indices are combinational from the request. The bench checks them a moment after it drives the request, before the clock edge at which the tag memory takes them. The response is built from the request captured at that edge and the memory word read at it, so it is due in the next cycle. A driver task queues each expected response at drive time. A monitor compares the head of the queue at the falling edge after the capturing edge. A response that arrives with nothing queued, or an item still queued at the end, is a failure. Stores are confirmed, or shown to have had no effect, by later tag loads compared against a reference copy of the tags in the bench.

// File: rtl/tagu_pkg.sv
package tagu_pkg;

    localparam int TAG_W       = 8;
    localparam int LANES       = 8;
    localparam int LINE_W      = TAG_W * LANES;
    localparam int LANE_IDX_W  = $clog2(LANES);
    localparam int DW_OFS_W    = 3;
    localparam int LINE_OFS_W  = DW_OFS_W + LANE_IDX_W;
    localparam int CAP_OFS_W   = DW_OFS_W + 1;
    localparam int RSP_W       = 64;

    localparam logic [TAG_W-1:0] TAG_UNTAGGED = 8'd252;
    localparam logic [TAG_W-1:0] TAG_CAP_LO   = 8'd254;
    localparam logic [TAG_W-1:0] TAG_CAP_HI   = 8'd255;

    typedef enum logic [2:0] {
        OP_TAG_LOAD   = 3'd0,
        OP_TAG_STORE  = 3'd1,
        OP_TAG_STORE8 = 3'd2,
        OP_CAP_LOAD   = 3'd3,
        OP_CAP_STORE  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        CS_NONE   = 3'd0,
        CS_ALIGN  = 3'd1,
        CS_PRIV   = 3'd2,
        CS_CAPTAG = 3'd3,
        CS_BADOP  = 3'd4
    } cause_e;

    typedef struct packed {
        logic                  valid;
        op_e                   op;
        logic [LANE_IDX_W-1:0] lane;
        cause_e                cause;
    } stage_s;

    // Values at or above the untagged marker may only be written by machine mode
    function automatic logic tag_needs_mmode(input logic [TAG_W-1:0] t);
        return t >= TAG_UNTAGGED;
    endfunction

    // Capability pair always starts on the even lane
    function automatic logic [LANE_IDX_W-1:0] pair_base(input logic [LANE_IDX_W-1:0] l);
        return {l[LANE_IDX_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/tagu_decode.sv
module tagu_decode
    import tagu_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic                  in_valid,
    input  logic [2:0]            in_op,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [TAG_W-1:0]      in_tag,
    input  logic [LINE_W-1:0]     in_tags,
    input  logic                  in_mmode,
    output cause_e                cause,
    output logic [LANE_IDX_W-1:0] lane,
    output logic                  rd_en,
    output logic [LANES-1:0]      wr_en,
    output logic [LINE_W-1:0]     wr_data
);

    logic [LANES-1:0]  lane_priv;
    logic [LINE_W-1:0] cap_pattern;
    logic              line_misaligned;
    logic              cap_misaligned;
    logic              ld_out_of_mmode;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_priv[g] = tag_needs_mmode(in_tags[g*TAG_W +: TAG_W]);
        if (g % 2 == 0) begin : g_even
            assign cap_pattern[g*TAG_W +: TAG_W] = TAG_CAP_LO;
        end else begin : g_odd
            assign cap_pattern[g*TAG_W +: TAG_W] = TAG_CAP_HI;
        end
    end

    assign lane            = in_addr[LINE_OFS_W-1:DW_OFS_W];
    assign line_misaligned = |in_addr[LINE_OFS_W-1:0];
    assign cap_misaligned  = |in_addr[CAP_OFS_W-1:0];
    assign ld_out_of_mmode = !in_mmode;

    always_comb begin
        cause   = CS_NONE;
        rd_en   = 1'b0;
        wr_en   = '0;
        wr_data = '0;
        if (in_valid) begin
            case (in_op)
                OP_TAG_LOAD: begin
                    rd_en = 1'b1;
                end
                OP_TAG_STORE: begin
                    if (ld_out_of_mmode && tag_needs_mmode(in_tag)) begin
                        cause = CS_PRIV;
                    end else begin
                        wr_en   = LANES'(1) << lane;
                        wr_data = {LANES{in_tag}};
                    end
                end
                OP_TAG_STORE8: begin
                    if (line_misaligned) begin
                        cause = CS_ALIGN;
                    end else if (ld_out_of_mmode && (|lane_priv)) begin
                        cause = CS_PRIV;
                    end else begin
                        wr_en   = '1;
                        wr_data = in_tags;
                    end
                end
                OP_CAP_LOAD: begin
                    if (cap_misaligned) begin
                        cause = CS_ALIGN;
                    end else begin
                        rd_en = 1'b1;
                    end
                end
                OP_CAP_STORE: begin
                    if (cap_misaligned) begin
                        cause = CS_ALIGN;
                    end else begin
                        wr_en   = LANES'(2'b11) << pair_base(lane);
                        wr_data = cap_pattern;
                    end
                end
                default: begin
                    cause = CS_BADOP;
                end
            endcase
        end
    end

endmodule

// File: rtl/tagu_lane_pick.sv
module tagu_lane_pick
    import tagu_pkg::*;
(
    input  logic [LINE_W-1:0]     line,
    input  logic [LANE_IDX_W-1:0] lane,
    output logic [TAG_W-1:0]      sel_tag,
    output logic                  cap_pair_ok
);

    logic [TAG_W-1:0] lane_tags [LANES];
    logic [LANE_IDX_W-1:0] lo_idx;
    logic [LANE_IDX_W-1:0] hi_idx;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_tags[g] = line[g*TAG_W +: TAG_W];
    end

    assign lo_idx      = pair_base(lane);
    assign hi_idx      = lo_idx | LANE_IDX_W'(1);
    assign sel_tag     = lane_tags[lane];
    assign cap_pair_ok = (lane_tags[lo_idx] == TAG_CAP_LO) &&
                         (lane_tags[hi_idx] == TAG_CAP_HI);

endmodule

// File: rtl/tagu_respond.sv
module tagu_respond
    import tagu_pkg::*;
(
    input  stage_s            st,
    input  logic [LINE_W-1:0] rdata,
    output logic              rsp_valid,
    output logic              rsp_exc,
    output logic [2:0]        rsp_cause,
    output logic [RSP_W-1:0]  rsp_data
);

    logic [TAG_W-1:0] sel_tag;
    logic             pair_ok;
    cause_e           final_cause;

    tagu_lane_pick u_pick (
        .line        (rdata),
        .lane        (st.lane),
        .sel_tag     (sel_tag),
        .cap_pair_ok (pair_ok)
    );

    always_comb begin
        final_cause = st.cause;
        if (st.cause == CS_NONE && st.op == OP_CAP_LOAD && !pair_ok) begin
            final_cause = CS_CAPTAG;
        end
    end

    always_comb begin
        rsp_valid = st.valid;
        rsp_exc   = st.valid && (final_cause != CS_NONE);
        rsp_cause = st.valid ? final_cause : CS_NONE;
        rsp_data  = '0;
        if (st.valid && final_cause == CS_NONE && st.op == OP_TAG_LOAD) begin
            rsp_data = RSP_W'(sel_tag);
        end
    end

endmodule

// File: rtl/tag_guard_unit.sv
module tag_guard_unit
    import tagu_pkg::*;
#(
    parameter int ADDR_W = 48,
    localparam int IDX_W = ADDR_W - LINE_OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [LINE_W-1:0] req_tags,
    input  logic              req_mmode,
    output logic              tm_re,
    output logic [IDX_W-1:0]  tm_ridx,
    input  logic [LINE_W-1:0] tm_rdata,
    output logic [LANES-1:0]  tm_we,
    output logic [IDX_W-1:0]  tm_widx,
    output logic [LINE_W-1:0] tm_wdata,
    output logic              rsp_valid,
    output logic              rsp_exc,
    output logic [2:0]        rsp_cause,
    output logic [RSP_W-1:0]  rsp_data
);

    cause_e                dec_cause;
    logic [LANE_IDX_W-1:0] dec_lane;
    stage_s                st_q;

    tagu_decode #(.ADDR_W(ADDR_W)) u_dec (
        .in_valid (req_valid),
        .in_op    (req_op),
        .in_addr  (req_addr),
        .in_tag   (req_tag),
        .in_tags  (req_tags),
        .in_mmode (req_mmode),
        .cause    (dec_cause),
        .lane     (dec_lane),
        .rd_en    (tm_re),
        .wr_en    (tm_we),
        .wr_data  (tm_wdata)
    );

    assign tm_ridx = req_addr[ADDR_W-1:LINE_OFS_W];
    assign tm_widx = req_addr[ADDR_W-1:LINE_OFS_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.valid <= req_valid;
            st_q.op    <= op_e'(req_op);
            st_q.lane  <= dec_lane;
            st_q.cause <= dec_cause;
        end
    end

    tagu_respond u_rsp (
        .st        (st_q),
        .rdata     (tm_rdata),
        .rsp_valid (rsp_valid),
        .rsp_exc   (rsp_exc),
        .rsp_cause (rsp_cause),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/tagu_checker.sv
module tagu_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic [5:0] addr_lo,
    input logic [7:0] req_tag,
    input logic       req_mmode,
    input logic [7:0] tm_we,
    input logic       tm_re,
    input logic       rsp_valid,
    input logic [2:0] rsp_cause
);

    AST_WRITE_NEEDS_STORE: assert property (@(posedge clk) disable iff (rst)
        (tm_we != 8'h00) |-> (req_valid && (req_op == 3'd1 || req_op == 3'd2 || req_op == 3'd4))); // R2

    AST_ST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd1) |-> ($countones(tm_we) <= 1)); // R2

    AST_ST_PRIV_GATE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd1 && !req_mmode && req_tag >= 8'd252) |-> (tm_we == 8'h00)); // R3

    AST_ST8_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd2) |-> (tm_we == 8'h00 || tm_we == 8'hFF)); // R5

    AST_ST8_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd2 && addr_lo != 6'd0) |-> (tm_we == 8'h00)); // R5

    AST_CAP_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 3'd3 || req_op == 3'd4) && addr_lo[3:0] != 4'd0)
        |-> (tm_we == 8'h00 && !tm_re)); // R7

    AST_SC_TWO_LANES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd4 && addr_lo[3:0] == 4'd0) |-> ($countones(tm_we) == 2)); // R8

    AST_BADOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op > 3'd4) |-> (tm_we == 8'h00 && !tm_re)); // R9

    AST_BADOP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op > 3'd4) |=> (rsp_cause == 3'd4)); // R9

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R10

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R10

endmodule

bind tag_guard_unit tagu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .addr_lo   (req_addr[5:0]),
    .req_tag   (req_tag),
    .req_mmode (req_mmode),
    .tm_we     (tm_we),
    .tm_re     (tm_re),
    .rsp_valid (rsp_valid),
    .rsp_cause (rsp_cause)
);

// File: tb/sim_tag_guard_unit.sv
module sim_tag_guard_unit;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 48;
    localparam int IDX_W      = ADDR_W - 6;

    logic              clk;
    logic              rst;
    logic              req_valid;
    logic [2:0]        req_op;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        req_tag;
    logic [63:0]       req_tags;
    logic              req_mmode;
    logic              tm_re;
    logic [IDX_W-1:0]  tm_ridx;
    logic [63:0]       tm_rdata;
    logic [7:0]        tm_we;
    logic [IDX_W-1:0]  tm_widx;
    logic [63:0]       tm_wdata;
    logic              rsp_valid;
    logic              rsp_exc;
    logic [2:0]        rsp_cause;
    logic [63:0]       rsp_data;

    tag_guard_unit #(.ADDR_W(ADDR_W)) u0 (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_op (req_op), .req_addr (req_addr),
        .req_tag (req_tag), .req_tags (req_tags), .req_mmode (req_mmode),
        .tm_re (tm_re), .tm_ridx (tm_ridx), .tm_rdata (tm_rdata),
        .tm_we (tm_we), .tm_widx (tm_widx), .tm_wdata (tm_wdata),
        .rsp_valid (rsp_valid), .rsp_exc (rsp_exc),
        .rsp_cause (rsp_cause), .rsp_data (rsp_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Tag memory: 64 lines of eight tags, synchronous read
    logic [63:0] mem [0:63];
    logic [63:0] rd_q;
    assign tm_rdata = rd_q;
    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        rd_q = '0;
    end
    always @(posedge clk) begin
        if (tm_re) rd_q <= mem[tm_ridx[5:0]];
        for (int l = 0; l < 8; l++)
            if (tm_we[l]) mem[tm_widx[5:0]][l*8 +: 8] <= tm_wdata[l*8 +: 8];
    end

    // Reference copy of the tags, one per doubleword
    logic [7:0] refm [0:511];
    initial for (int i = 0; i < 512; i++) refm[i] = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [2:0]  q_cause [$];
    logic [63:0] q_data  [$];
    string       q_rid   [$];

    task automatic check(input bit ok, input string rid, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rid, what, act, exp);
        end
    endtask

    // Monitor: compares responses against the queue
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q_rid.size() == 0) begin
                check(1'b0, "R10", "response without request", 64'd1, 64'd0);
            end else begin
                automatic string       rid = q_rid.pop_front();
                automatic logic [2:0]  ec  = q_cause.pop_front();
                automatic logic [63:0] ed  = q_data.pop_front();
                check(rsp_exc == (ec != 3'd0), rid, "exception flag", 64'(rsp_exc), 64'(ec != 3'd0));
                check(rsp_cause == ec, rid, "cause", 64'(rsp_cause), 64'(ec));
                check(rsp_data == ed, rid, "data", rsp_data, ed);
            end
        end
    end

    // Driver: computes expectations from the requirements and checks the memory-side outputs
    task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] addr,
                         input logic [7:0] tag, input logic [63:0] tags,
                         input bit mm, input string rid);
        logic [7:0]  ewe;
        logic [63:0] ewd;
        logic        ere;
        logic [2:0]  ec;
        logic [63:0] ed;
        int lane, dw, line, pr;
        bit anyp;
        lane = int'(addr[5:3]);
        dw   = int'(addr[11:3]);
        line = int'(addr[11:6]);
        pr   = int'({addr[11:4], 1'b0});
        ewe = '0; ewd = '0; ere = 1'b0; ec = 3'd0; ed = '0;
        case (op)
            3'd0: begin ere = 1'b1; ed = {56'd0, refm[dw]}; end
            3'd1: begin
                if (!mm && tag >= 8'd252) ec = 3'd2;
                else begin ewe[lane] = 1'b1; ewd[lane*8 +: 8] = tag; end
            end
            3'd2: begin
                anyp = 0;
                for (int i = 0; i < 8; i++) if (tags[i*8 +: 8] >= 8'd252) anyp = 1;
                if (addr[5:0] != 0) ec = 3'd1;
                else if (!mm && anyp) ec = 3'd2;
                else begin ewe = 8'hFF; ewd = tags; end
            end
            3'd3: begin
                if (addr[3:0] != 0) ec = 3'd1;
                else begin
                    ere = 1'b1;
                    if (!(refm[pr] == 8'd254 && refm[pr+1] == 8'd255)) ec = 3'd3;
                end
            end
            3'd4: begin
                if (addr[3:0] != 0) ec = 3'd1;
                else begin
                    ewe[pr%8] = 1'b1; ewe[pr%8+1] = 1'b1;
                    ewd[(pr%8)*8 +: 8] = 8'd254; ewd[(pr%8+1)*8 +: 8] = 8'd255;
                end
            end
            default: ec = 3'd4;
        endcase
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_tag = tag; req_tags = tags; req_mmode = mm;
        #1;
        check(tm_we == ewe, rid, "write enables", 64'(tm_we), 64'(ewe));
        check(tm_re == ere, rid, "read enable", 64'(tm_re), 64'(ere));
        for (int i = 0; i < 8; i++)
            if (ewe[i]) check(tm_wdata[i*8 +: 8] == ewd[i*8 +: 8], rid, "write lane",
                              64'(tm_wdata[i*8 +: 8]), 64'(ewd[i*8 +: 8]));
        if (ewe != 0) check(tm_widx == IDX_W'(line), rid, "write line", 64'(tm_widx), 64'(line));
        if (ere) check(tm_ridx == IDX_W'(line), rid, "read line", 64'(tm_ridx), 64'(line));
        q_cause.push_back(ec);
        q_data.push_back(ed);
        q_rid.push_back(rid);
        for (int i = 0; i < 8; i++)
            if (ewe[i]) refm[line*8 + i] = ewd[i*8 +: 8];
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0;
        req_tag = '0; req_tags = '0; req_mmode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        check(tm_we == 8'h00, "R10", "reset tm_we", 64'(tm_we), 64'd0);
        check(tm_re == 1'b0, "R10", "reset tm_re", 64'(tm_re), 64'd0);
        rst = 1'b0;

        // R1: unwritten location reads zero
        issue(3'd0, 48'h0C8, 8'd0, 64'd0, 1'b0, "R1");
        // R2: single store, low bits ignored, then readback
        issue(3'd1, 48'h05D, 8'd17, 64'd0, 1'b0, "R2");
        issue(3'd0, 48'h05A, 8'd0, 64'd0, 1'b0, "R1");
        // R3: privileged values
        issue(3'd1, 48'h058, 8'd252, 64'd0, 1'b0, "R3");
        issue(3'd0, 48'h058, 8'd0, 64'd0, 1'b0, "R3");
        issue(3'd1, 48'h060, 8'd255, 64'd0, 1'b1, "R3");
        issue(3'd0, 48'h060, 8'd0, 64'd0, 1'b0, "R3");
        idle();
        idle();
        // R4: eight-tag store and readback of two lanes
        issue(3'd2, 48'h080, 8'd0, 64'h0807_0605_0403_0201, 1'b0, "R4");
        issue(3'd0, 48'h080, 8'd0, 64'd0, 1'b0, "R4");
        issue(3'd0, 48'h0BF, 8'd0, 64'd0, 1'b0, "R4");
        // R5: misaligned and privileged eight-tag stores
        issue(3'd2, 48'h088, 8'd0, 64'h1111_1111_1111_1111, 1'b1, "R5");
        issue(3'd2, 48'h080, 8'd0, 64'h2222_FD22_2222_2222, 1'b0, "R5");
        issue(3'd0, 48'h080, 8'd0, 64'd0, 1'b0, "R5");
        issue(3'd2, 48'h100, 8'd0, 64'hFFFE_0000_0000_00FC, 1'b1, "R5");
        issue(3'd0, 48'h138, 8'd0, 64'd0, 1'b0, "R5");
        // R8 and R6: stamp pair then load it
        issue(3'd4, 48'h0D0, 8'd0, 64'd0, 1'b0, "R8");
        issue(3'd3, 48'h0D0, 8'd0, 64'd0, 1'b0, "R6");
        issue(3'd0, 48'h0D8, 8'd0, 64'd0, 1'b0, "R8");
        issue(3'd3, 48'h050, 8'd0, 64'd0, 1'b0, "R6");
        issue(3'd1, 48'h140, 8'd254, 64'd0, 1'b1, "R6");
        issue(3'd1, 48'h148, 8'd100, 64'd0, 1'b1, "R6");
        issue(3'd3, 48'h140, 8'd0, 64'd0, 1'b0, "R6");
        issue(3'd1, 48'h140, 8'd255, 64'd0, 1'b1, "R6");
        issue(3'd1, 48'h148, 8'd254, 64'd0, 1'b1, "R6");
        issue(3'd3, 48'h140, 8'd0, 64'd0, 1'b0, "R6");
        // R7: misaligned capability accesses
        issue(3'd3, 48'h0D8, 8'd0, 64'd0, 1'b1, "R7");
        issue(3'd4, 48'h0C4, 8'd0, 64'd0, 1'b1, "R7");
        issue(3'd0, 48'h0C0, 8'd0, 64'd0, 1'b0, "R7");
        // R9: unknown opcodes
        issue(3'd5, 48'h000, 8'd0, 64'd0, 1'b1, "R9");
        issue(3'd7, 48'h040, 8'd9, 64'hFF, 1'b0, "R9");
        idle();
        repeat (3) idle();
        check(q_rid.size() == 0, "R10", "responses outstanding", 64'(q_rid.size()), 64'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule